// File: doc/BRIEF.md
# Pattern-Restarted Programmable Watchdog

This block is a supervisory timer that asks for a system reset when software stops servicing it. A prescaler divides the core clock into a 100 ms tick. A tick counter compares the tick count against a timeout limit. The limit is loaded from a 5-bit timeout code, but only when the timer restarts. Software reaches the block through a byte-wide register write port and reads the control register back.

Software arms the watchdog by writing the control register at address 0Ah. It services the watchdog by writing a key nibble to address 09h. The counter keeps running whether or not the enable bit is set. Only an enabled expiry produces a request. The timeout code of all ones parks the counter and its prescaler.

The block also holds itself in restart while the supply-good input is low. It restarts when the external reset pulse is released.

Top module: `pattern_watchdog`

## Requirements
- R1: After reset, `rd_data` reads 8'h1F (enable 0, timeout code 31) and the latched limit is the stop code. No request appears until a restart loads a runnable code, even if the control register is changed first.
- R2: A write to address 8'h0A sets the enable from `wr_data[7]` and the timeout code from `wr_data[4:0]`. From the next cycle `rd_data` reads {enable, 2'b00, code}. Writes to any other address leave `rd_data` unchanged.
- R3: A write to address 8'h09 whose low nibble is 4'b1010 restarts the timer, whatever the upper nibble holds. If the latched limit is L ticks and enable is set, `wdt_reset_req` is high in exactly the cycle that follows L*TICK_CYCLES clock edges after the restart edge.
- R4: A write to 8'h09 with any other low nibble, or a key nibble written to any other address, does not change when the pending request occurs.
- R5: A latched code of 0 gives a limit of 1 tick. A code n from 1 to 30 gives n ticks.
- R6: Changing the timeout code does not alter the count in progress. The new code is used from the next restart.
- R7: While enable is clear the counter still runs, and its expiry produces no request. The enable value at the expiry edge decides whether the request fires.
- R8: A latched code of 31 stops the counter and prescaler, so no request ever occurs until a restart loads another code.
- R9: A one-cycle pulse on `rst_release` restarts the timer in the same way as the key write.
- R10: While `supply_ok` is low the timer is held in restart and no request is made. Counting resumes from the last cycle in which `supply_ok` was low.
- R11: The request is a single-cycle pulse. After expiry the counter holds, and no further request occurs until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Readback of the control register {enable, 2'b00, code} |
| supply_ok | input | 1 | High while the supply is above its trip point |
| rst_release | input | 1 | One-cycle pulse at the end of the system reset pulse |
| wdt_reset_req | output | 1 | One-cycle timeout request |

## Verification
The assertions take for granted the following input conventions:
- `rst_release` is a one-cycle pulse.
- No register write is issued in the two cycles in which the internal reset is still being released.
- `wr_addr`, `wr_data` and `wr_en` are steady around the rising edge.

The stimulus respects these by driving every input on the falling edge. It waits several cycles after releasing reset before the first write, and it raises `rst_release` for exactly one cycle.

The bench shortens the prescaler to four cycles. This keeps full-range timeouts of up to 30 ticks inside a short run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int CODE_W = 5;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t      CODE_STOP    = '1;
  localparam logic [7:0] ADDR_SERVICE = 8'h09;
  localparam logic [7:0] ADDR_CTRL    = 8'h0A;
  localparam logic [3:0] SERVICE_KEY  = 4'b1010;
  localparam int         EN_BIT       = 7;

  // Code 0 is clamped to the one-tick minimum; other codes map one to one.
  function automatic code_t limit_of(code_t c);
    return (c == '0) ? code_t'(1) : c;
  endfunction

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int TICK_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);

  localparam int PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;
  logic          pre_ce;
  logic          at_last;

  assign at_last = (pre_q == LAST);
  assign pre_ce  = clear | run;

  always_comb begin
    pre_d = pre_q;
    if (clear) begin
      pre_d = '0;
    end else if (run) begin
      pre_d = at_last ? '0 : pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_ce) begin
      pre_q <= pre_d;
    end
  end

  assign tick = run & ~clear & at_last;

endmodule

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       enable,
  output code_t      code,
  output logic       service,
  output logic [7:0] rd_data
);

  logic  en_q, en_d;
  code_t code_q, code_d;
  logic  ctrl_we;
  logic  unused_rsvd;

  assign ctrl_we     = wr_en && (wr_addr == ADDR_CTRL);
  assign service     = wr_en && (wr_addr == ADDR_SERVICE) && (wr_data[3:0] == SERVICE_KEY);
  assign unused_rsvd = ^wr_data[6:5];

  always_comb begin
    en_d   = wr_data[EN_BIT];
    code_d = wr_data[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= CODE_STOP;
    end else if (ctrl_we) begin
      en_q   <= en_d;
      code_q <= code_d;
    end
  end

  assign enable  = en_q;
  assign code    = code_q;
  assign rd_data = {en_q, 2'b00, code_q};

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int TICK_CYCLES = 20_000_000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  supply_ok,
  input  logic  enable,
  input  code_t code,
  output logic  req
);

  code_t limit_q, limit_d;
  code_t cnt_q, cnt_d;
  logic  expired_q, expired_d;
  logic  req_q, req_d;
  logic  clr, run, tick, state_ce;
  code_t cnt_inc;

  assign clr      = restart | ~supply_ok;
  assign run      = supply_ok & ~expired_q & (limit_q != CODE_STOP);
  assign cnt_inc  = cnt_q + code_t'(1);
  assign state_ce = clr | tick | req_q;

  wdog_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clr),
    .run   (run),
    .tick  (tick)
  );

  always_comb begin
    limit_d   = limit_q;
    cnt_d     = cnt_q;
    expired_d = expired_q;
    req_d     = 1'b0;
    if (clr) begin
      limit_d   = limit_of(code);
      cnt_d     = '0;
      expired_d = 1'b0;
    end else if (tick) begin
      cnt_d = cnt_inc;
      if (cnt_inc == limit_q) begin
        expired_d = 1'b1;
        req_d     = enable;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q   <= CODE_STOP;
      cnt_q     <= '0;
      expired_q <= 1'b0;
      req_q     <= 1'b0;
    end else if (state_ce) begin
      limit_q   <= limit_d;
      cnt_q     <= cnt_d;
      expired_q <= expired_d;
      req_q     <= req_d;
    end
  end

  assign req = req_q;

endmodule

// File: rtl/pattern_watchdog.sv
module pattern_watchdog
  import wdog_pkg::*;
#(
  parameter int TICK_CYCLES = 20_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       supply_ok,
  input  logic       rst_release,
  output logic       wdt_reset_req
);

  logic  srst_n;
  logic  enable;
  code_t code;
  logic  service;
  logic  restart;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wdog_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .enable  (enable),
    .code    (code),
    .service (service),
    .rd_data (rd_data)
  );

  assign restart = service | rst_release;

  wdog_counter #(.TICK_CYCLES(TICK_CYCLES)) u_cnt (
    .clk       (clk),
    .rst_n     (srst_n),
    .restart   (restart),
    .supply_ok (supply_ok),
    .enable    (enable),
    .code      (code),
    .req       (wdt_reset_req)
  );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       supply_ok,
  input logic       rst_release,
  input logic       wdt_reset_req
);

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CTRL) |=>
      rd_data == {$past(wr_data[7]), 2'b00, $past(wr_data[4:0])});

  assert_key_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_SERVICE && wr_data[3:0] == SERVICE_KEY) |=> !wdt_reset_req);

  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |-> $past(rd_data[EN_BIT]));

  assert_release_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_release |=> !wdt_reset_req);

  assert_supply_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |-> $past(supply_ok));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> !wdt_reset_req);

endmodule

bind pattern_watchdog wdog_checker u_wdog_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .rd_data       (rd_data),
  .supply_ok     (supply_ok),
  .rst_release   (rst_release),
  .wdt_reset_req (wdt_reset_req)
);

// File: tb/tb_pattern_watchdog.sv
`timescale 1ns/1ps
module tb_pattern_watchdog;

  localparam int T = 4;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       supply_ok;
  logic       rst_release;
  logic       wdt_reset_req;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc;
  int   checks;
  int   errors;
  bit   mon_on;
  bit   done;
  int   c;

  pattern_watchdog #(.TICK_CYCLES(T)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .supply_ok     (supply_ok),
    .rst_release   (rst_release),
    .wdt_reset_req (wdt_reset_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare each request against the scoreboard queue.
  always @(negedge clk) begin
    if (mon_on) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s missed request: actual none at cycle %0d, expected at %0d",
                 q[0].tag, cyc, q[0].cyc);
        void'(q.pop_front());
      end
      if (wdt_reset_req) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R11/unexpected request: actual at cycle %0d, expected none", cyc);
        end else if (q[0].cyc != cyc) begin
          errors++;
          $display("FAIL %s request: actual cycle %0d, expected %0d", q[0].tag, cyc, q[0].cyc);
        end else begin
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic push(input int at, input string tag);
    exp_t e;
    e.cyc = at;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int at);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    at      = cyc;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(input int n, input string tag);
    idle(n);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s pending requests: actual %0d, expected 0", tag, q.size());
      q.delete();
    end
  endtask

  task automatic check_rd(input logic [7:0] exp, input string tag);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd_data: actual %02h, expected %02h", tag, rd_data, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; mon_on = 0; done = 0;
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    supply_ok = 1; rst_release = 0;
    idle(4);
    rst_n = 1;
    idle(5);
    mon_on = 1;

    // R1: reset state; stop code stays latched until a restart
    check_rd(8'h1F, "R1");
    checks++;
    if (wdt_reset_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 req after reset: actual %b, expected 0", wdt_reset_req);
    end
    wr(8'h0A, 8'h80, c);
    settle(50, "R1");

    // R2: register write and readback, reserved bits, foreign addresses
    wr(8'h0A, 8'hE3, c);
    check_rd(8'h83, "R2");
    wr(8'h0B, 8'h00, c);
    check_rd(8'h83, "R2");
    wr(8'h09, 8'h7F, c);
    check_rd(8'h83, "R2");

    // R3/R11: key write with upper nibble set, code 3, one pulse
    wr(8'h09, 8'hFA, c);
    push(c + 1 + 3*T, "R3");
    settle(40, "R3");
    settle(20, "R11");

    // R5: code 0 is one tick, code 30 is thirty ticks
    wr(8'h0A, 8'h80, c);
    wr(8'h09, 8'h0A, c);
    push(c + 1 + 1*T, "R5");
    settle(12, "R5");
    wr(8'h0A, 8'h9E, c);
    wr(8'h09, 8'h0A, c);
    push(c + 1 + 30*T, "R5");
    settle(130, "R5");

    // R4: non-key writes do not disturb the pending timeout
    wr(8'h0A, 8'h83, c);
    wr(8'h09, 8'h0A, c);
    push(c + 1 + 3*T, "R4");
    wr(8'h09, 8'h05, c);
    wr(8'h09, 8'hAB, c);
    wr(8'h19, 8'h0A, c);
    settle(30, "R4");

    // R6: new code only at the next restart
    wr(8'h0A, 8'h82, c);
    wr(8'h09, 8'h0A, c);
    push(c + 1 + 2*T, "R6");
    wr(8'h0A, 8'h85, c);
    settle(20, "R6");
    wr(8'h09, 8'h0A, c);
    push(c + 1 + 5*T, "R6");
    settle(30, "R6");

    // R7: disabled expiry is silent; enabling mid-count keeps the schedule
    wr(8'h0A, 8'h03, c);
    wr(8'h09, 8'h0A, c);
    settle(30, "R7");
    wr(8'h09, 8'h0A, c);
    push(c + 1 + 3*T, "R7");
    idle(3);
    wr(8'h0A, 8'h83, c);
    settle(30, "R7");
    settle(30, "R11");

    // R8: stop code parks the counter
    wr(8'h0A, 8'h9F, c);
    wr(8'h09, 8'h0A, c);
    settle(200, "R8");
    wr(8'h0A, 8'h81, c);
    settle(50, "R8");
    wr(8'h09, 8'h0A, c);
    push(c + 1 + 1*T, "R8");
    settle(12, "R8");

    // R9: release pulse restarts the count
    wr(8'h0A, 8'h82, c);
    wr(8'h09, 8'h0A, c);
    idle(2);
    rst_release = 1'b1;
    c = cyc;
    idle(1);
    rst_release = 1'b0;
    push(c + 1 + 2*T, "R9");
    settle(20, "R9");

    // R10: low supply holds the timer in restart
    wr(8'h09, 8'h0A, c);
    idle(1);
    supply_ok = 1'b0;
    idle(5);
    supply_ok = 1'b1;
    c = cyc;
    push(c + 2*T, "R10");
    settle(20, "R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule